// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Controller

This block watches an input port of parallel pins and turns selected transitions on them into a single interrupt request. Software programs two write-only registers over a simple write bus. The mask register decides which pins may interrupt. The direction register decides, for each pin, whether a rising or a falling transition counts. All qualifying pins feed one shared request line. That line stays high until the interrupt handler pulses an acknowledge input.

Every pin first passes through a synchronizer. A transition is found by comparing the synchronized level with its value one clock earlier. Only a transition on the pin itself can raise the request. Rewriting the mask or the direction bits never creates an event on its own. An event that arrives in the same cycle as an acknowledge is not lost: the request stays raised.

Top module: `ped_irq_ctrl`

## Requirements
- R1: After reset, both configuration registers hold all zeros and `irq` is low. With the mask register still zero, transitions on any pin leave `irq` low.
- R2: A write with `wr_addr` = 0x31 loads the mask register from `wr_data`. Bit n set allows pin n to interrupt.
- R3: A write with `wr_addr` = 0x32 loads the direction register from `wr_data`. For an enabled pin, bit n = 1 selects rising transitions (0 to 1) and bit n = 0 selects falling transitions (1 to 0). A transition in the other direction has no effect.
- R4: A transition on a pin whose mask bit is 0 does not raise `irq`.
- R5: A qualifying transition on any enabled pin raises the same `irq` output.
- R6: Once raised, `irq` stays high until `irq_ack` is high at a rising clock edge. That edge clears `irq`, unless R7 applies.
- R7: If a new qualifying transition is detected in the same cycle that `irq_ack` is high, `irq` stays high.
- R8: Writing the mask or direction register while the pins are steady does not raise `irq`.
- R9: A write to any address other than 0x31 or 0x32 changes neither register.
- R10: Suppose a new pin level is present at rising edge k. Then `irq` is still low after edge k+1 and high after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration bus |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data, one bit per pin |
| pins | input | 8 | Asynchronous port pins |
| irq_ack | input | 1 | Acknowledge pulse that clears the pending request |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, a two-stage synchronizer, the mask register at 0x31 and the direction register at 0x32. With these values the exact detection latency of R10 can be checked cycle by cycle. The eight-bit port also allows one pin to be enabled while a disabled neighbour toggles. An acknowledge can be placed in the very cycle a second pin's transition is detected. Writes to the neighbouring addresses 0x30 and 0x33 exercise the address decode.

// File: rtl/ped_pkg.sv
package ped_pkg;

    localparam int unsigned PED_WIDTH       = 8;
    localparam int unsigned PED_ADDR_W      = 8;
    localparam int unsigned PED_SYNC_STAGES = 2;
    localparam logic [7:0]  PED_MASK_ADDR   = 8'h31;
    localparam logic [7:0]  PED_DIR_ADDR    = 8'h32;

    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } ped_dir_e;

endpackage

// File: rtl/ped_sync.sv
module ped_sync #(
    parameter int unsigned WIDTH  = ped_pkg::PED_WIDTH,
    parameter int unsigned STAGES = ped_pkg::PED_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.chain[LAST];

endmodule

// File: rtl/ped_cfg.sv
module ped_cfg #(
    parameter int unsigned WIDTH     = ped_pkg::PED_WIDTH,
    parameter int unsigned ADDR_W    = ped_pkg::PED_ADDR_W,
    parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(ped_pkg::PED_MASK_ADDR),
    parameter logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(ped_pkg::PED_DIR_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  mask,
    output logic [WIDTH-1:0]  dir
);

    typedef struct packed {
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] dir;
    } cfg_state_t;

    cfg_state_t c_d, c_q;
    logic       hit_mask;
    logic       hit_dir;

    always_comb begin
        hit_mask = wr_en && (wr_addr == MASK_ADDR);
        hit_dir  = wr_en && (wr_addr == DIR_ADDR);
        c_d      = c_q;
        if (hit_mask) begin
            c_d.mask = wr_data;
        end
        if (hit_dir) begin
            c_d.dir = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mask = c_q.mask;
    assign dir  = c_q.dir;

endmodule

// File: rtl/ped_detect.sv
module ped_detect #(
    parameter int unsigned WIDTH = ped_pkg::PED_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] hit
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } det_state_t;

    det_state_t d_d, d_q;

    always_comb begin
        d_d      = d_q;
        d_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic went_up;
        logic went_down;
        always_comb begin
            went_up   = level[g] & ~d_q.prev[g];
            went_down = ~level[g] & d_q.prev[g];
            if (dir[g] == ped_pkg::DIR_RISE) begin
                hit[g] = mask[g] & went_up;
            end else begin
                hit[g] = mask[g] & went_down;
            end
        end
    end

endmodule

// File: rtl/ped_pend.sv
module ped_pend #(
    parameter int unsigned WIDTH = ped_pkg::PED_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit,
    input  logic             ack,
    output logic             req
);

    typedef struct packed {
        logic pending;
    } pend_state_t;

    pend_state_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (ack) begin
            p_d.pending = 1'b0;
        end
        if (|hit) begin
            p_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign req = p_q.pending;

endmodule

// File: rtl/ped_irq_ctrl.sv
module ped_irq_ctrl #(
    parameter int unsigned WIDTH       = ped_pkg::PED_WIDTH,
    parameter int unsigned ADDR_W      = ped_pkg::PED_ADDR_W,
    parameter int unsigned SYNC_STAGES = ped_pkg::PED_SYNC_STAGES,
    parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(ped_pkg::PED_MASK_ADDR),
    parameter logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(ped_pkg::PED_DIR_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  pins,
    input  logic              irq_ack,
    output logic              irq
);

    logic [WIDTH-1:0] level_w;
    logic [WIDTH-1:0] mask_w;
    logic [WIDTH-1:0] dir_w;
    logic [WIDTH-1:0] hit_w;

    ped_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .dout  (level_w)
    );

    ped_cfg #(
        .WIDTH     (WIDTH),
        .ADDR_W    (ADDR_W),
        .MASK_ADDR (MASK_ADDR),
        .DIR_ADDR  (DIR_ADDR)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mask    (mask_w),
        .dir     (dir_w)
    );

    ped_detect #(
        .WIDTH (WIDTH)
    ) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level_w),
        .mask  (mask_w),
        .dir   (dir_w),
        .hit   (hit_w)
    );

    ped_pend #(
        .WIDTH (WIDTH)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_w),
        .ack   (irq_ack),
        .req   (irq)
    );

endmodule

// File: rtl/ped_irq_ctrl_chk.sv
module ped_irq_ctrl_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             irq_ack,
    input logic [WIDTH-1:0] hit,
    input logic [WIDTH-1:0] mask
);

    // R1: request is low whenever reset is held at a clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!irq);
        end
    end

    // R4: a detection never comes from a masked pin
    p_masked_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~mask) == '0);

    // R5: any detection raises the request on the next edge
    p_hit_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> irq);

    // R6: without acknowledge the request holds
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R6: acknowledge with no new detection drops the request
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && (hit == '0)) |=> !irq);

    // R7: detection coincident with acknowledge keeps the request
    p_ack_race_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && (|hit)) |=> irq);

    // R8: the request never rises without a detection one cycle earlier
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|hit));

endmodule

bind ped_irq_ctrl ped_irq_ctrl_chk #(
    .WIDTH (WIDTH)
) u_ped_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .irq_ack (irq_ack),
    .hit     (hit_w),
    .mask    (mask_w)
);

// File: tb/test_ped_irq_ctrl.sv
`timescale 1ns/1ps
module test_ped_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pins = '0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    ped_irq_ctrl i_ped_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pins    (pins),
        .irq_ack (irq_ack),
        .irq     (irq)
    );

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (irq !== e.val) begin
                    n_fails++;
                    $display("FAIL %s: irq=%0b expected %0b", e.tag, irq, e.val);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_irq(logic v, string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic put_pins(logic [7:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(posedge clk);
        #1;
        irq_ack = 1'b0;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: irq=%0b expected run to complete", irq);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_irq(1'b0, "R1 reset state");
        rst_n = 1'b1;
        tick(2);
        // R1: mask zero after reset, edges ignored
        put_pins(8'hFF); tick(4);
        expect_irq(1'b0, "R1 rise with reset mask");
        put_pins(8'h00); tick(4);
        expect_irq(1'b0, "R1 fall with reset mask");

        // R2/R3/R10: pin0 enabled, rising
        write_reg(8'h31, 8'h01);
        write_reg(8'h32, 8'h01);
        tick(3);
        expect_irq(1'b0, "R8 config writes alone");
        put_pins(8'h01);
        tick(2);
        expect_irq(1'b0, "R10 not yet after two edges");
        tick(1);
        expect_irq(1'b1, "R10 raised after third edge");
        expect_irq(1'b1, "R2 pin0 enabled rise");
        tick(5);
        expect_irq(1'b1, "R6 sticky without ack");
        ack();
        expect_irq(1'b0, "R6 cleared by ack");

        // R3: falling edge ignored in rising mode
        put_pins(8'h00); tick(4);
        expect_irq(1'b0, "R3 fall ignored in rise mode");

        // R8: switch pin0 to falling while steady
        write_reg(8'h32, 8'h00); tick(3);
        expect_irq(1'b0, "R8 direction change no event");
        put_pins(8'h01); tick(4);
        expect_irq(1'b0, "R3 rise ignored in fall mode");
        put_pins(8'h00); tick(3);
        expect_irq(1'b1, "R3 falling edge detected");
        ack();
        expect_irq(1'b0, "R6 cleared after fall");

        // R4: disabled neighbour toggles
        put_pins(8'h08); tick(4);
        put_pins(8'h00); tick(4);
        expect_irq(1'b0, "R4 masked pin3 ignored");

        // R5: shared line from upper pins
        write_reg(8'h31, 8'hF0);
        write_reg(8'h32, 8'hF0);
        tick(2);
        put_pins(8'h40); tick(3);
        expect_irq(1'b1, "R5 pin6 raises shared irq");
        ack();
        expect_irq(1'b0, "R6 clear pin6");
        put_pins(8'h50); tick(3);
        expect_irq(1'b1, "R5 pin4 raises shared irq");
        ack();
        expect_irq(1'b0, "R6 clear pin4");

        // R7: ack in the detection cycle of pin7
        put_pins(8'h70); tick(3);
        expect_irq(1'b1, "R5 pin5 raises shared irq");
        put_pins(8'hF0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b1;
        @(posedge clk);
        #1;
        irq_ack = 1'b0;
        expect_irq(1'b1, "R7 edge with ack keeps irq");
        ack();
        expect_irq(1'b0, "R7 later ack clears");

        // R9: neighbouring addresses leave registers unchanged
        write_reg(8'h30, 8'hFF);
        write_reg(8'h33, 8'h0F);
        tick(2);
        put_pins(8'hF1); tick(4);
        put_pins(8'hF0); tick(4);
        expect_irq(1'b0, "R9 stray writes leave pin0 masked");
        put_pins(8'h70); tick(4);
        expect_irq(1'b0, "R9 direction still rising for pin7");

        // R8: widening the mask over high pins
        put_pins(8'hF0); tick(3);
        expect_irq(1'b1, "R3 pin7 rise");
        ack();
        write_reg(8'h31, 8'hFF);
        write_reg(8'h32, 8'h0F);
        tick(4);
        expect_irq(1'b0, "R8 mask and direction change while steady");

        // R1: reset mid-run clears pending and registers
        put_pins(8'h00); tick(3);
        expect_irq(1'b1, "R3 pins falling in fall mode");
        @(negedge clk);
        rst_n = 1'b0;
        tick(1);
        expect_irq(1'b0, "R1 reset drops irq");
        rst_n = 1'b1;
        tick(3);
        put_pins(8'hFF); tick(4);
        put_pins(8'h00); tick(4);
        expect_irq(1'b0, "R1 mask cleared by reset");

        tick(2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule